// File: doc/BRIEF.md
# Multi-Slot Maskable Interrupt Aggregator

This block collects interrupt requests from a set of peripheral slots and merges them into one interrupt towards the host. Each slot has two request lines. Two more sources are added to them: a power-good fault input and a software-controlled force bit. Every source is captured either as a sticky edge event or as a live level, and every source has its own mask. The unmasked, pending sources are ORed into one combined request.

The combined request drives one of two outputs, selected by a mode bit. In message mode it produces one-cycle pulses, each of which the surrounding fabric turns into a message write. In legacy mode it produces a level line that stays high while anything is pending. A programmable spacing timer limits how often the output may signal. A message pulse starts the timer, and so does a rising edge of the legacy line. The timer sets both the minimum distance between pulses and the minimum high time of the legacy line.

Software reaches the block through a small word-addressed register port. Writes take effect at the clock edge. Read data is registered and appears one cycle after the address. All inputs are taken as synchronous to `clk`.

Top module: `irq_combiner`

## Requirements
- R1: After a synchronous reset both interrupt outputs are low. Reset also sets the mask register (address 0) to all ones, and clears the trigger-select register (address 1), the control register (address 2), the spacing register (address 3) and all status bits.
- R2: The source bit index is fixed. Slot s line l is bit 2s+l. The power-good fault is bit 2·NUM_SLOTS. The software force bit is bit 2·NUM_SLOTS+1. The status register (address 4) uses this index.
- R3: A source whose trigger-select bit is 1 is edge-triggered. A rising edge sets its status bit, and the bit stays set after the input falls. Writing 1 to that bit at address 4 clears it. Writing 0 leaves it unchanged.
- R4: A source whose trigger-select bit is 0 is level-triggered. Its status bit follows the input with one cycle of delay. Writing 1 to it at address 4 has no effect.
- R5: A mask bit of 1 keeps its source out of the combined request, but the source's status bit stays visible. The pending register (address 5) reads status AND NOT mask. With nothing pending, neither output asserts.
- R6: Control bit 0 is the software force bit. It acts as a level source at its own index, and it is masked like any other source.
- R7: With control bit 1 set (message mode), a rise of the combined request gives a one-cycle `msi_irq` pulse two cycles after the source input rises. In this mode `inta_irq` stays low.
- R8: In message mode, successive pulses are at least SPACING+1 cycles apart. If a request is still pending when the spacing timer runs out, one more pulse follows exactly SPACING+1 cycles after the previous pulse. If nothing is pending at that point, no pulse follows.
- R9: With control bit 1 clear (legacy mode), `inta_irq` rises two cycles after a source input rises. It stays high as long as any unmasked status is pending. In this mode `msi_irq` stays low.
- R10: In legacy mode, `inta_irq` stays high for at least SPACING+1 cycles after it rises, even if the request goes away sooner. It falls on the first edge at which both the request is gone and that interval has passed.
- R11: Reads return the addressed register one cycle after the address is presented. Addresses with no register read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_irq | input | 2*NUM_SLOTS | Request lines, slot s line l at bit 2s+l |
| pwr_fault | input | 1 | Power-good fault request |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| msi_irq | output | 1 | One-cycle message interrupt pulse |
| inta_irq | output | 1 | Legacy level interrupt |

## Verification
The bench tests the spacing timer at its edges. A design that is off by one cycle would place the second message pulse one cycle early or late, or would drop the legacy line one cycle before the interval has passed. It also checks that a request which is gone when the timer runs out produces no extra pulse; a design that fires on every expiry would fail here. A masked source must still appear in status but must not reach either output; a design that applies the mask before the status bits would fail that check. Edge-mode status must survive a write of zero and clear on a write of one, and level-mode status must ignore clear writes; a design that lets clear writes reach the live level would fail those checks.

// File: rtl/irq_combiner_pkg.sv
package irq_combiner_pkg;
  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RA_MASK   = 3'd0,
    RA_EDGE   = 3'd1,
    RA_CTRL   = 3'd2,
    RA_SPACE  = 3'd3,
    RA_STATUS = 3'd4,
    RA_PEND   = 3'd5
  } reg_addr_e;

  localparam int unsigned CTRL_FORCE_BIT = 0;
  localparam int unsigned CTRL_MSI_BIT   = 1;
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell (
  input  logic clk,
  input  logic rst,
  input  logic src_in,
  input  logic edge_mode,
  input  logic clr,
  output logic status
);
  logic src_q;
  logic sticky_q;
  logic rise;

  assign rise = src_in & ~src_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q    <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      src_q <= src_in;
      if (edge_mode && rise) begin
        sticky_q <= 1'b1;
      end else if (clr) begin
        sticky_q <= 1'b0;
      end
    end
  end

  assign status = edge_mode ? sticky_q : src_q;
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_combiner_pkg::*;
#(
  parameter int unsigned NSRC    = 8,
  parameter int unsigned TIMER_W = 16,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [REG_AW-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NSRC-1:0]    status,
  output logic [NSRC-1:0]    mask_q,
  output logic [NSRC-1:0]    edge_q,
  output logic               force_q,
  output logic               msi_mode_q,
  output logic [TIMER_W-1:0] space_q,
  output logic [NSRC-1:0]    clr_vec,
  output logic [DATA_W-1:0]  rdata
);
  reg_addr_e         sel;
  logic [DATA_W-1:0] rd_nxt;
  logic              unused_wdata;

  assign sel          = reg_addr_e'(addr);
  assign unused_wdata = ^wdata;
  assign clr_vec      = (we && sel == RA_STATUS) ? wdata[NSRC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q     <= '1;
      edge_q     <= '0;
      force_q    <= 1'b0;
      msi_mode_q <= 1'b0;
      space_q    <= '0;
    end else if (we) begin
      case (sel)
        RA_MASK:  mask_q  <= wdata[NSRC-1:0];
        RA_EDGE:  edge_q  <= wdata[NSRC-1:0];
        RA_CTRL: begin
          force_q    <= wdata[CTRL_FORCE_BIT];
          msi_mode_q <= wdata[CTRL_MSI_BIT];
        end
        RA_SPACE: space_q <= wdata[TIMER_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_nxt = '0;
    case (sel)
      RA_MASK:   rd_nxt[NSRC-1:0]    = mask_q;
      RA_EDGE:   rd_nxt[NSRC-1:0]    = edge_q;
      RA_CTRL: begin
        rd_nxt[CTRL_FORCE_BIT] = force_q;
        rd_nxt[CTRL_MSI_BIT]   = msi_mode_q;
      end
      RA_SPACE:  rd_nxt[TIMER_W-1:0] = space_q;
      RA_STATUS: rd_nxt[NSRC-1:0]    = status;
      RA_PEND:   rd_nxt[NSRC-1:0]    = status & ~mask_q;
      default:   rd_nxt              = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_nxt;
  end
endmodule

// File: rtl/irq_rate_gen.sv
module irq_rate_gen #(
  parameter int unsigned TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               any_req,
  input  logic               msi_mode,
  input  logic [TIMER_W-1:0] space,
  output logic               msi_irq,
  output logic               inta_irq
);
  logic [TIMER_W-1:0] cnt_q;
  logic               prev_q;
  logic               exp_q;
  logic               busy;
  logic               fire;
  logic               inta_nxt;
  logic               load;

  assign busy     = (cnt_q != '0);
  assign fire     = msi_mode & any_req & ~busy & (~prev_q | exp_q);
  assign inta_nxt = ~msi_mode & (any_req ? (inta_irq | ~busy) : (inta_irq & busy));
  assign load     = fire | (inta_nxt & ~inta_irq);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      prev_q   <= 1'b0;
      exp_q    <= 1'b0;
      msi_irq  <= 1'b0;
      inta_irq <= 1'b0;
    end else begin
      prev_q   <= any_req;
      exp_q    <= (cnt_q == TIMER_W'(1));
      msi_irq  <= fire;
      inta_irq <= inta_nxt;
      if (load)      cnt_q <= space;
      else if (busy) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
  import irq_combiner_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 3,
  parameter int unsigned TIMER_W   = 16,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [2*NUM_SLOTS-1:0] slot_irq,
  input  logic                   pwr_fault,
  input  logic                   reg_we,
  input  logic [2:0]             reg_addr,
  input  logic [DATA_W-1:0]      reg_wdata,
  output logic [DATA_W-1:0]      reg_rdata,
  output logic                   msi_irq,
  output logic                   inta_irq
);
  localparam int unsigned NSRC = 2 * NUM_SLOTS + 2;

  logic [NSRC-1:0]    src_all;
  logic [NSRC-1:0]    status_vec;
  logic [NSRC-1:0]    mask_q;
  logic [NSRC-1:0]    edge_q;
  logic [NSRC-1:0]    clr_vec;
  logic               force_q;
  logic               msi_mode_q;
  logic [TIMER_W-1:0] space_q;
  logic               any_req;

  assign src_all = {force_q, pwr_fault, slot_irq};

  irq_regfile #(.NSRC(NSRC), .TIMER_W(TIMER_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .status(status_vec), .mask_q(mask_q), .edge_q(edge_q), .force_q(force_q),
    .msi_mode_q(msi_mode_q), .space_q(space_q), .clr_vec(clr_vec),
    .rdata(reg_rdata)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    irq_src_cell u_cell (
      .clk(clk), .rst(rst), .src_in(src_all[i]), .edge_mode(edge_q[i]),
      .clr(clr_vec[i]), .status(status_vec[i])
    );
  end

  assign any_req = |(status_vec & ~mask_q);

  irq_rate_gen #(.TIMER_W(TIMER_W)) u_rate (
    .clk(clk), .rst(rst), .any_req(any_req), .msi_mode(msi_mode_q),
    .space(space_q), .msi_irq(msi_irq), .inta_irq(inta_irq)
  );
endmodule

// File: rtl/irq_combiner_chk.sv
module irq_combiner_chk #(
  parameter int unsigned NSRC    = 8,
  parameter int unsigned TIMER_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               msi_irq,
  input logic               inta_irq,
  input logic               any_req,
  input logic               msi_mode,
  input logic [NSRC-1:0]    status,
  input logic [NSRC-1:0]    edge_sel,
  input logic [NSRC-1:0]    clr_vec,
  input logic [TIMER_W-1:0] space
);
  logic               rst_d;
  logic [TIMER_W:0]   gap_q;
  logic [TIMER_W-1:0] space_cap_q;
  logic               seen_q;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst_d) begin
      p_reset_quiet_r1: assert (!msi_irq && !inta_irq);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q       <= '0;
      space_cap_q <= '0;
      seen_q      <= 1'b0;
    end else if (msi_irq) begin
      gap_q       <= (TIMER_W+1)'(1);
      space_cap_q <= space;
      seen_q      <= 1'b1;
    end else if (gap_q != '1) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  p_msi_spacing_r8: assert property (@(posedge clk) disable iff (rst)
    (msi_irq && seen_q) |-> (gap_q > {1'b0, space_cap_q}));

  p_outputs_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
    !(msi_irq && inta_irq));

  p_no_pulse_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !any_req |=> !msi_irq);

  p_inta_no_spurious_r10: assert property (@(posedge clk) disable iff (rst)
    (!any_req && !inta_irq) |=> !inta_irq);

  p_inta_held_r9: assert property (@(posedge clk) disable iff (rst)
    (inta_irq && any_req) |=> (inta_irq || msi_mode));

  for (genvar i = 0; i < NSRC; i++) begin : g_sticky
    p_edge_sticky_r3: assert property (@(posedge clk) disable iff (rst)
      (edge_sel[i] && status[i] && !clr_vec[i]) |=> (status[i] || !edge_sel[i]));
  end
endmodule

bind irq_combiner irq_combiner_chk #(.NSRC(2 * NUM_SLOTS + 2), .TIMER_W(TIMER_W)) u_chk (
  .clk(clk), .rst(rst), .msi_irq(msi_irq), .inta_irq(inta_irq),
  .any_req(any_req), .msi_mode(msi_mode_q), .status(status_vec),
  .edge_sel(edge_q), .clr_vec(clr_vec), .space(space_q)
);

// File: tb/irq_combiner_bench.sv
module irq_combiner_bench;
  localparam int CLK_P     = 10;
  localparam int NUM_SLOTS = 3;
  localparam int TIMER_W   = 16;
  localparam int DATA_W    = 32;

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic [2*NUM_SLOTS-1:0] slot_irq = '0;
  logic                   pwr_fault = 1'b0;
  logic                   reg_we = 1'b0;
  logic [2:0]             reg_addr = '0;
  logic [DATA_W-1:0]      reg_wdata = '0;
  logic [DATA_W-1:0]      reg_rdata;
  logic                   msi_irq;
  logic                   inta_irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  irq_combiner #(.NUM_SLOTS(NUM_SLOTS), .TIMER_W(TIMER_W), .DATA_W(DATA_W)) u_irq_combiner (
    .clk(clk), .rst(rst), .slot_irq(slot_irq), .pwr_fault(pwr_fault),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .msi_irq(msi_irq), .inta_irq(inta_irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check(!msi_irq && !inta_irq, "R1 outputs", {30'd0, msi_irq, inta_irq}, 0);
    rd(3'd0, d); check(d == 32'hFF, "R1 mask", d, 32'hFF);
    rd(3'd1, d); check(d == 0, "R1 trigger select", d, 0);
    rd(3'd2, d); check(d == 0, "R1 control", d, 0);
    rd(3'd3, d); check(d == 0, "R1 spacing", d, 0);
    rd(3'd4, d); check(d == 0, "R1 status", d, 0);
    rd(3'd7, d); check(d == 0, "R11 unused address", d, 0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    @(negedge clk);
    slot_irq[2] = 1'b1; slot_irq[5] = 1'b1; pwr_fault = 1'b1;
    idle(2);
    rd(3'd4, d); check(d == 32'h64, "R2 index map", d, 32'h64);
    wr(3'd4, 32'hFF);
    rd(3'd4, d); check(d == 32'h64, "R4 clear ignored", d, 32'h64);
    @(negedge clk);
    slot_irq = '0; pwr_fault = 1'b0;
    idle(2);
    rd(3'd4, d); check(d == 0, "R4 follows input", d, 0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr(3'd1, 32'hFF);
    @(negedge clk); slot_irq[5] = 1'b1;
    @(negedge clk); slot_irq[5] = 1'b0;
    idle(2);
    rd(3'd4, d); check(d == 32'h20, "R3 sticky after fall", d, 32'h20);
    wr(3'd4, 32'h00);
    rd(3'd4, d); check(d == 32'h20, "R3 write zero keeps", d, 32'h20);
    wr(3'd4, 32'h20);
    rd(3'd4, d); check(d == 0, "R3 write one clears", d, 0);
    wr(3'd1, 32'h00);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    bit seen = 1'b0;
    wr(3'd2, 32'h0);
    @(negedge clk); slot_irq[1] = 1'b1;
    for (int k = 0; k < 4; k++) begin
      step();
      if (inta_irq || msi_irq) seen = 1'b1;
    end
    check(!seen, "R5 masked source silent", {31'd0, seen}, 0);
    rd(3'd4, d); check(d == 32'h02, "R5 status visible", d, 32'h02);
    rd(3'd5, d); check(d == 0, "R5 pending masked", d, 0);
    wr(3'd0, 32'hFD);
    step();
    check(inta_irq, "R5 unmask asserts", {31'd0, inta_irq}, 1);
    rd(3'd5, d); check(d == 32'h02, "R5 pending", d, 32'h02);
    @(negedge clk); slot_irq = '0;
    idle(4);
    wr(3'd0, 32'h00);
  endtask

  task automatic t_legacy();
    bit ok;
    wr(3'd2, 32'h0);
    wr(3'd3, 32'd5);
    @(negedge clk); slot_irq[0] = 1'b1;
    step();
    check(!inta_irq, "R9 not yet", {31'd0, inta_irq}, 0);
    step();
    check(inta_irq, "R9 asserts two cycles", {31'd0, inta_irq}, 1);
    slot_irq[0] = 1'b0;
    ok = 1'b1;
    for (int k = 0; k < 5; k++) begin
      step();
      if (!inta_irq || msi_irq) ok = 1'b0;
    end
    check(ok, "R10 held for spacing", {31'd0, ok}, 1);
    step();
    check(!inta_irq, "R10 release after spacing", {31'd0, inta_irq}, 0);
    wr(3'd3, 32'd0);
    idle(3);
    @(negedge clk); slot_irq[3] = 1'b1;
    idle(2);
    ok = 1'b1;
    for (int k = 0; k < 10; k++) begin
      step();
      if (!inta_irq || msi_irq) ok = 1'b0;
    end
    check(ok, "R9 held while pending", {31'd0, ok}, 1);
    slot_irq[3] = 1'b0;
    step();
    check(inta_irq, "R9 still one cycle", {31'd0, inta_irq}, 1);
    step();
    check(!inta_irq, "R9 drops after clear", {31'd0, inta_irq}, 0);
  endtask

  task automatic t_msi();
    bit ok;
    wr(3'd2, 32'h2);
    wr(3'd3, 32'd4);
    idle(3);
    @(negedge clk); slot_irq[3] = 1'b1;
    step(); step();
    check(msi_irq && !inta_irq, "R7 pulse two cycles", {30'd0, msi_irq, inta_irq}, 32'h2);
    ok = 1'b1;
    for (int k = 0; k < 4; k++) begin
      step();
      if (msi_irq || inta_irq) ok = 1'b0;
    end
    check(ok, "R8 quiet during spacing", {31'd0, ok}, 1);
    step();
    check(msi_irq, "R8 repeat at spacing+1", {31'd0, msi_irq}, 1);
    slot_irq[3] = 1'b0;
    step();
    check(!msi_irq, "R7 one cycle wide", {31'd0, msi_irq}, 0);
    ok = 1'b1;
    for (int k = 0; k < 8; k++) begin
      step();
      if (msi_irq) ok = 1'b0;
    end
    check(ok, "R8 no pulse when cleared", {31'd0, ok}, 1);
  endtask

  task automatic t_force();
    logic [31:0] d;
    bit seen = 1'b0;
    wr(3'd3, 32'd0);
    wr(3'd0, 32'h80);
    idle(6);
    wr(3'd2, 32'h3);
    for (int k = 0; k < 4; k++) begin
      step();
      if (msi_irq) seen = 1'b1;
    end
    check(!seen, "R6 masked force silent", {31'd0, seen}, 0);
    rd(3'd4, d); check(d == 32'h80, "R6 force status", d, 32'h80);
    rd(3'd2, d); check(d == 32'h3, "R11 control readback", d, 32'h3);
    wr(3'd0, 32'h00);
    step();
    check(msi_irq, "R6 force unmasked pulse", {31'd0, msi_irq}, 1);
    wr(3'd2, 32'h2);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_level();
    t_edge();
    t_mask();
    t_legacy();
    idle(10);
    t_msi();
    idle(10);
    t_force();
    idle(5);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule